// File: doc/BRIEF.md
# Flash Command Interface Mode Controller

This block is a clocked model of the command decoder and read-mode selector that sits at the front of a parallel NOR flash. A host writes one-byte commands on the low data lines during write cycles. The block keeps a read mode that decides what a later read cycle returns: array contents, identifier and protection words, query table entries, or the status word.

The identifier and query words are fetched from small tables outside the block through their own address and data ports. The array is reached the same way. Four sticky status flags record lock, programming-voltage, program and erase events reported by internal operation logic. That logic can only set the flags, and only the clear command removes them.

All host bus pins are sampled through one register stage. A read cycle is recognised when the later of chip enable and output enable falls while write enable and the device reset pin are high. At that moment the address and the mode are captured, and the output word is then held until the read ends.

Top module: `nor_cmd_frontend`

## Requirements
- R1: After `rst_n` is low at a clock edge, the mode is read-array, `bus_dq_oe` is 0 and `bus_dout` is 0; the first read then returns array data.
- R2: Command 8'hFF (on `bus_din`) selects read-array mode, in which a read of any address returns the 16-bit `arr_data` for that address, with `arr_addr` equal to the captured address.
- R3: Command 8'h90 selects identifier mode only when the bank field (the top `BANK_W` address bits) is zero; reads then return `id_data` with `id_addr` equal to the low `ID_AW` bits of the captured address. In any other bank the command is ignored.
- R4: Command 8'h98 selects query mode only in bank zero; reads then return `qry_data` with `qry_addr` equal to the low `QRY_AW` bits of the captured address. In any other bank the command is ignored.
- R5: Command 8'h70 selects status mode; a read returns 16'h0080 with bit 5 = erase flag, bit 4 = program flag, bit 3 = voltage flag and bit 1 = lock flag, all other bits 0.
- R6: Command 8'h50 clears all four flags and selects read-array mode.
- R7: A one-cycle pulse on an `evt_*` input sets its flag, which stays set until a clear command; a pulse in the same cycle as the clear leaves that flag set.
- R8: `bus_dq_oe` is 1 only during a read: chip enable and output enable low, write enable and `bus_rp_n` high. Otherwise it is 0.
- R9: The address is captured when the later of the two enables falls. `bus_dout` and `bus_dq_oe=1` appear on the second clock edge after the edge that samples that fall, and `bus_dout` stays stable while the read continues, even if the address changes.
- R10: In identifier mode every command is ignored except 8'hFF written to bank zero, which returns the block to read-array mode.
- R11: A command is taken when write enable rises while chip enable is low. A write-enable rise with chip enable high is ignored, and an unlisted code leaves the mode unchanged.
- R12: While `bus_rp_n` is low the mode is forced to read-array and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Host chip enable, active low |
| bus_oe_n | input | 1 | Host output enable, active low |
| bus_we_n | input | 1 | Host write enable, active low |
| bus_rp_n | input | 1 | Host device reset pin, active low |
| bus_addr | input | ADDR_W | Host word address |
| bus_din | input | 8 | Low data lines carrying the command byte |
| bus_dout | output | 16 | Read data to the host |
| bus_dq_oe | output | 1 | High while the block drives read data |
| arr_addr | output | ADDR_W | Array read address |
| arr_data | input | 16 | Array read data |
| id_addr | output | ID_AW | Identifier table address |
| id_data | input | 16 | Identifier table word |
| qry_addr | output | QRY_AW | Query table address |
| qry_data | input | 16 | Query table word |
| evt_lock | input | 1 | Set pulse for the lock flag |
| evt_vpp | input | 1 | Set pulse for the programming-voltage flag |
| evt_prog | input | 1 | Set pulse for the program flag |
| evt_erase | input | 1 | Set pulse for the erase flag |

## Verification
The bench builds the block with a 10-bit address, a 2-bit bank field, a 3-bit identifier table address and a 5-bit query table address. With these values all four banks lie within a short address range, so the bank-zero condition on the identifier and query commands can be tested from both sides. Table index wrap-around also shows up with small addresses. The narrow tables let the bench model the identifier and query contents as simple functions of the address. Each read changes the address while it is held, and one read lowers output enable before chip enable, to show where the address is captured.

// File: rtl/nor_cmd_pkg.sv
// Package: shared read-mode type, command opcodes and status word layout
// for the flash command front end. Assumes one-byte opcodes.
package nor_cmd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_IDENT  = 2'd1,
        RM_QUERY  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;

    localparam logic [7:0] OP_ARRAY  = 8'hFF;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_QUERY  = 8'h98;
    localparam logic [7:0] OP_STATUS = 8'h70;
    localparam logic [7:0] OP_CLEAR  = 8'h50;

    localparam int NUM_FLAGS = 4;
    localparam int FLG_LOCK  = 0;
    localparam int FLG_VPP   = 1;
    localparam int FLG_PROG  = 2;
    localparam int FLG_ERASE = 3;

    // Build the 16-bit status word from the sticky flags; ready reads as 1.
    function automatic logic [15:0] status_word(input logic [NUM_FLAGS-1:0] f);
        logic [15:0] w;
        w     = '0;
        w[7]  = 1'b1;
        w[5]  = f[FLG_ERASE];
        w[4]  = f[FLG_PROG];
        w[3]  = f[FLG_VPP];
        w[1]  = f[FLG_LOCK];
        return w;
    endfunction

endpackage

// File: rtl/nor_bus_sampler.sv
// Module: registers the host bus pins once and derives the command strobe
// and read-start event. Assumes the host pins are synchronous to clk or
// slow enough that one register stage is sufficient.
module nor_bus_sampler #(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [ADDR_W-1:0] s_addr,
    output logic [7:0]        s_din,
    output logic              rp_ok,
    output logic              cmd_stb,
    output logic              rd_now,
    output logic              rd_start
);

    logic s_ce_n, s_oe_n, s_we_n, s_rp_n;
    logic we_prev, rd_prev;

    // Sample every bus pin; idle values are the inactive levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_ce_n  <= 1'b1;
            s_oe_n  <= 1'b1;
            s_we_n  <= 1'b1;
            s_rp_n  <= 1'b1;
            s_addr  <= '0;
            s_din   <= '0;
            we_prev <= 1'b1;
            rd_prev <= 1'b0;
        end else begin
            s_ce_n  <= ce_n;
            s_oe_n  <= oe_n;
            s_we_n  <= we_n;
            s_rp_n  <= rp_n;
            s_addr  <= addr;
            s_din   <= din;
            we_prev <= s_we_n;
            rd_prev <= rd_now;
        end
    end

    // Decode write strobe and read window from the sampled pins.
    always_comb begin
        rp_ok    = s_rp_n;
        cmd_stb  = s_we_n && !we_prev && !s_ce_n && s_rp_n;
        rd_now   = !s_ce_n && !s_oe_n && s_we_n && s_rp_n;
        rd_start = rd_now && !rd_prev;
    end

    // A read start is a single-cycle event.
    p_start_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start |=> !rd_start);

endmodule

// File: rtl/nor_mode_fsm.sv
// Module: read-mode state machine. Decodes command bytes on the strobe,
// applies the bank-zero rule for identifier and query entry and the
// identifier-mode lock, and issues the flag clear pulse.
module nor_mode_fsm
    import nor_cmd_pkg::*;
#(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rp_ok,
    input  logic              cmd_stb,
    input  logic [7:0]        code,
    input  logic [BANK_W-1:0] bank,
    output rd_mode_e          mode,
    output logic              clr_stb
);

    rd_mode_e mode_q, mode_d;
    logic     bank0;

    // Next mode and clear pulse from the current command.
    always_comb begin
        bank0   = (bank == '0);
        mode_d  = mode_q;
        clr_stb = 1'b0;
        if (!rp_ok) begin
            mode_d = RM_ARRAY;
        end else if (cmd_stb) begin
            if (mode_q == RM_IDENT) begin
                if (code == OP_ARRAY && bank0) mode_d = RM_ARRAY;
            end else begin
                unique case (code)
                    OP_ARRAY:  mode_d = RM_ARRAY;
                    OP_STATUS: mode_d = RM_STATUS;
                    OP_CLEAR: begin
                        mode_d  = RM_ARRAY;
                        clr_stb = 1'b1;
                    end
                    OP_IDENT:  if (bank0) mode_d = RM_IDENT;
                    OP_QUERY:  if (bank0) mode_d = RM_QUERY;
                    default:   mode_d = mode_q;
                endcase
            end
        end
    end

    // Mode register; power-up state is read-array.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= RM_ARRAY;
        else        mode_q <= mode_d;
    end

    assign mode = mode_q;

    p_reset_array_r1: assert property (@(posedge clk)
        !rst_n |=> mode_q == RM_ARRAY);

    p_ident_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RM_IDENT && rp_ok && !(cmd_stb && code == OP_ARRAY && bank == '0))
        |=> mode_q == RM_IDENT);

    p_clear_array_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb) |=> mode_q == RM_ARRAY);

    p_rp_array_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_ok |=> mode_q == RM_ARRAY);

endmodule

// File: rtl/nor_status_flags.sv
// Module: sticky status flags. Event pulses set flags; only the clear
// pulse resets them, and a set in the same cycle as a clear wins.
module nor_status_flags
    import nor_cmd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [NUM_FLAGS-1:0] evt,
    output logic [NUM_FLAGS-1:0] flags
);

    logic [NUM_FLAGS-1:0] flags_q;

    // Clear first, then OR in the new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (clr ? '0 : flags_q) | evt;
    end

    assign flags = flags_q;

    p_no_hw_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    p_evt_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

endmodule

// File: rtl/nor_read_path.sv
// Module: read data path. Captures address and mode at the read start,
// drives the table addresses, and loads the output word one cycle later.
// The output is held for the rest of the read.
module nor_read_path
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int ID_AW  = 4,
    parameter int QRY_AW = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_now,
    input  logic                 rd_start,
    input  logic [ADDR_W-1:0]    s_addr,
    input  rd_mode_e             mode,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [ADDR_W-1:0]    arr_addr,
    input  logic [15:0]          arr_data,
    output logic [ID_AW-1:0]     id_addr,
    input  logic [15:0]          id_data,
    output logic [QRY_AW-1:0]    qry_addr,
    input  logic [15:0]          qry_data,
    output logic [15:0]          dout,
    output logic                 dq_oe
);

    logic [ADDR_W-1:0] lat_addr;
    rd_mode_e          lat_mode;
    logic              lat_pend;
    logic [15:0]       rd_word;

    // Capture address and mode at the later enable fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr <= '0;
            lat_mode <= RM_ARRAY;
            lat_pend <= 1'b0;
        end else begin
            lat_pend <= rd_start;
            if (rd_start) begin
                lat_addr <= s_addr;
                lat_mode <= mode;
            end
        end
    end

    // Table addresses follow the captured address.
    always_comb begin
        arr_addr = lat_addr;
        id_addr  = lat_addr[ID_AW-1:0];
        qry_addr = lat_addr[QRY_AW-1:0];
    end

    // Select the word for the captured mode.
    always_comb begin
        unique case (lat_mode)
            RM_IDENT:  rd_word = id_data;
            RM_QUERY:  rd_word = qry_data;
            RM_STATUS: rd_word = status_word(flags);
            default:   rd_word = arr_data;
        endcase
    end

    // Load the output word once per read and drive while the read lasts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= '0;
            dq_oe <= 1'b0;
        end else begin
            if (lat_pend) dout <= rd_word;
            if (!rd_now)       dq_oe <= 1'b0;
            else if (lat_pend) dq_oe <= 1'b1;
        end
    end

    p_oe_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> !dq_oe);

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && rd_now) |=> (!dq_oe || $stable(dout)));

endmodule

// File: rtl/nor_cmd_frontend.sv
// Module: top of the flash command front end. Joins the bus sampler, the
// mode state machine, the sticky flags and the read path. Assumes the bank
// field is the top BANK_W address bits and the tables are read
// combinationally.
module nor_cmd_frontend
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 2,
    parameter int ID_AW  = 4,
    parameter int QRY_AW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_ce_n,
    input  logic              bus_oe_n,
    input  logic              bus_we_n,
    input  logic              bus_rp_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_din,
    output logic [15:0]       bus_dout,
    output logic              bus_dq_oe,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic [15:0]       arr_data,
    output logic [ID_AW-1:0]  id_addr,
    input  logic [15:0]       id_data,
    output logic [QRY_AW-1:0] qry_addr,
    input  logic [15:0]       qry_data,
    input  logic              evt_lock,
    input  logic              evt_vpp,
    input  logic              evt_prog,
    input  logic              evt_erase
);

    localparam int BANK_LSB = ADDR_W - BANK_W;

    logic [ADDR_W-1:0]    s_addr;
    logic [7:0]           s_din;
    logic                 rp_ok, cmd_stb, rd_now, rd_start, clr_stb;
    rd_mode_e             mode;
    logic [NUM_FLAGS-1:0] evt, flags;

    // Pack the event pulses by flag index.
    always_comb begin
        evt            = '0;
        evt[FLG_LOCK]  = evt_lock;
        evt[FLG_VPP]   = evt_vpp;
        evt[FLG_PROG]  = evt_prog;
        evt[FLG_ERASE] = evt_erase;
    end

    nor_bus_sampler #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n),
        .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n), .rp_n(bus_rp_n),
        .addr(bus_addr), .din(bus_din),
        .s_addr(s_addr), .s_din(s_din), .rp_ok(rp_ok),
        .cmd_stb(cmd_stb), .rd_now(rd_now), .rd_start(rd_start)
    );

    nor_mode_fsm #(.BANK_W(BANK_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .rp_ok(rp_ok), .cmd_stb(cmd_stb),
        .code(s_din), .bank(s_addr[ADDR_W-1:BANK_LSB]),
        .mode(mode), .clr_stb(clr_stb)
    );

    nor_status_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(clr_stb), .evt(evt), .flags(flags)
    );

    nor_read_path #(.ADDR_W(ADDR_W), .ID_AW(ID_AW), .QRY_AW(QRY_AW)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_now(rd_now), .rd_start(rd_start),
        .s_addr(s_addr), .mode(mode), .flags(flags),
        .arr_addr(arr_addr), .arr_data(arr_data),
        .id_addr(id_addr), .id_data(id_data),
        .qry_addr(qry_addr), .qry_data(qry_data),
        .dout(bus_dout), .dq_oe(bus_dq_oe)
    );

    p_reset_outputs_r1: assert property (@(posedge clk)
        !rst_n |=> (!bus_dq_oe && bus_dout == 16'h0000));

endmodule

// File: tb/nor_cmd_frontend_tb.sv
// Bench: scoreboard style. The read task pushes the expected word, and a
// monitor pops it when the output-enable of the design rises.
module nor_cmd_frontend_tb_top;

    localparam int ADDR_W = 10;
    localparam int BANK_W = 2;
    localparam int ID_AW  = 3;
    localparam int QRY_AW = 5;
    localparam logic [ADDR_W-1:0] BANK1 = 10'h100;
    localparam logic [ADDR_W-1:0] BANK2 = 10'h200;
    localparam logic [ADDR_W-1:0] BANK3 = 10'h300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_ce_n = 1'b1, bus_oe_n = 1'b1, bus_we_n = 1'b1, bus_rp_n = 1'b1;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic [15:0] bus_dout;
    logic        bus_dq_oe;
    logic [ADDR_W-1:0] arr_addr;
    logic [ID_AW-1:0]  id_addr;
    logic [QRY_AW-1:0] qry_addr;
    logic [15:0] arr_data, id_data, qry_data;
    logic evt_lock = 0, evt_vpp = 0, evt_prog = 0, evt_erase = 0;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        oe_seen = 1'b0;

    always #2.5 clk = ~clk;

    // Table models for the bench.
    assign arr_data = 16'hC000 ^ {6'b0, arr_addr};
    assign id_data  = 16'h2C00 | {13'b0, id_addr};
    assign qry_data = 16'h5100 | {11'b0, qry_addr};

    nor_cmd_frontend #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .ID_AW(ID_AW), .QRY_AW(QRY_AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n), .bus_rp_n(bus_rp_n),
        .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_dq_oe(bus_dq_oe),
        .arr_addr(arr_addr), .arr_data(arr_data), .id_addr(id_addr), .id_data(id_data),
        .qry_addr(qry_addr), .qry_data(qry_data),
        .evt_lock(evt_lock), .evt_vpp(evt_vpp), .evt_prog(evt_prog), .evt_erase(evt_erase)
    );

    function automatic logic [15:0] exp_arr(input logic [ADDR_W-1:0] a);
        return 16'hC000 ^ {6'b0, a};
    endfunction
    function automatic logic [15:0] exp_id(input logic [ADDR_W-1:0] a);
        return 16'h2C00 | {13'b0, a[2:0]};
    endfunction
    function automatic logic [15:0] exp_qry(input logic [ADDR_W-1:0] a);
        return 16'h5100 | {11'b0, a[4:0]};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare each new read word against the scoreboard.
    always @(negedge clk) begin
        if (bus_dq_oe && !oe_seen) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected read", bus_dout, 16'h0000);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_dout == e, t, bus_dout, e);
            end
        end
        oe_seen = bus_dq_oe;
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] c, input bit ce_on);
        @(negedge clk);
        bus_addr = a; bus_din = c; bus_ce_n = !ce_on; bus_we_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Clear command with an erase event in the cycle the clear is applied.
    task automatic clear_with_erase(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        bus_addr = a; bus_din = 8'h50; bus_ce_n = 1'b0; bus_we_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_we_n = 1'b1;
        @(negedge clk);
        evt_erase = 1'b1;
        @(negedge clk);
        evt_erase = 1'b0;
        bus_ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Read with chip enable first; address changes during the hold.
    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [15:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a; bus_ce_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_oe_n = 1'b0;
        repeat (4) @(negedge clk);
        bus_addr = ~a;
        repeat (2) @(negedge clk);
        chk(bus_dq_oe && bus_dout == e, "R9 held word", bus_dout, e);
        bus_oe_n = 1'b1; bus_ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Read with output enable first; chip enable falls later with a new address.
    task automatic bus_read_late(input logic [ADDR_W-1:0] a1, input logic [ADDR_W-1:0] a2,
                                 input logic [15:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_addr = a1; bus_oe_n = 1'b0;
        repeat (3) @(negedge clk);
        bus_addr = a2; bus_ce_n = 1'b0;
        repeat (5) @(negedge clk);
        bus_oe_n = 1'b1; bus_ce_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: evt_lock = 1'b1;
            1: evt_vpp = 1'b1;
            2: evt_prog = 1'b1;
            default: evt_erase = 1'b1;
        endcase
        @(negedge clk);
        evt_lock = 0; evt_vpp = 0; evt_prog = 0; evt_erase = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        chk(!bus_dq_oe && bus_dout == 16'h0000, "R1 reset outputs", bus_dout, 16'h0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(10'h035, exp_arr(10'h035), "R1 array after reset");

        bus_write(10'h000, 8'hFF, 1'b1);
        bus_read(10'h2A7, exp_arr(10'h2A7), "R2 array read");
        bus_read_late(10'h011, 10'h3C4, exp_arr(10'h3C4), "R9 later enable address");

        pulse(2); pulse(0);
        bus_write(10'h000, 8'h70, 1'b1);
        bus_read(10'h000, 16'h0092, "R5 status prog+lock");
        bus_write(10'h000, 8'h20, 1'b1);
        bus_read(10'h005, 16'h0092, "R11 unknown code keeps status, R7 flags held");

        bus_write(BANK2, 8'h50, 1'b1);
        bus_read(10'h040, exp_arr(10'h040), "R6 clear returns to array");
        bus_write(10'h000, 8'h70, 1'b1);
        bus_read(10'h000, 16'h0080, "R6 flags cleared");

        pulse(1);
        clear_with_erase(10'h000);
        bus_write(10'h000, 8'h70, 1'b1);
        bus_read(10'h000, 16'h00A0, "R7 set wins over clear");

        bus_write(BANK1, 8'h90, 1'b1);
        bus_read(10'h002, 16'h00A0, "R3 ident ignored outside bank zero");
        bus_write(10'h000, 8'h90, 1'b1);
        bus_read(10'h002, exp_id(10'h002), "R3 ident word");
        bus_read(10'h0F5, exp_id(10'h0F5), "R3 ident index wrap");

        bus_write(10'h000, 8'h70, 1'b1);
        bus_read(10'h003, exp_id(10'h003), "R10 status ignored in ident");
        bus_write(BANK1, 8'hFF, 1'b1);
        bus_read(10'h001, exp_id(10'h001), "R10 exit ignored outside bank zero");
        bus_write(10'h000, 8'hFF, 1'b1);
        bus_read(10'h155, exp_arr(10'h155), "R10 exit in bank zero");

        bus_write(BANK3, 8'h98, 1'b1);
        bus_read(10'h007, exp_arr(10'h007), "R4 query ignored outside bank zero");
        bus_write(10'h000, 8'h98, 1'b1);
        bus_read(10'h013, exp_qry(10'h013), "R4 query word");
        bus_read(10'h3FF, exp_qry(10'h3FF), "R4 query index wrap");

        bus_write(10'h000, 8'h70, 1'b0);
        bus_read(10'h004, exp_qry(10'h004), "R11 write with chip enable high ignored");

        // R8: write enable low blocks a read.
        @(negedge clk);
        bus_ce_n = 1'b0; bus_we_n = 1'b0; bus_oe_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(!bus_dq_oe, "R8 no drive with write enable low", {15'b0, bus_dq_oe}, 16'h0000);
        bus_oe_n = 1'b1; bus_ce_n = 1'b1;
        @(negedge clk);
        bus_we_n = 1'b1;
        repeat (2) @(negedge clk);

        // R12: device reset pin forces array mode and blocks writes and reads.
        bus_rp_n = 1'b0;
        repeat (2) @(negedge clk);
        bus_write(10'h000, 8'h70, 1'b1);
        bus_ce_n = 1'b0; bus_oe_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(!bus_dq_oe, "R8 no drive with reset pin low", {15'b0, bus_dq_oe}, 16'h0000);
        bus_ce_n = 1'b1; bus_oe_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_rp_n = 1'b1;
        repeat (2) @(negedge clk);
        bus_read(10'h0AA, exp_arr(10'h0AA), "R12 array after reset pin");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all reads produced", 16'(exp_q.size()), 16'h0000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule